// File: doc/BRIEF.md
# Pulse-Count Nibble Tape Encoder

This block writes a byte buffer to a cassette-style audio channel. It switches on the recorder motor and waits a warm-up time before it sends anything. It then sends the buffer as a series of pulse bursts, one burst per 4-bit nibble. The number of pulses in a burst carries the nibble value. A fixed silent gap separates two bursts, so a reader can tell where one nibble ends and the next begins.

Each buffer is framed. The first buffer after reset opens the record with two start words. Every buffer closes with three stop words. When the buffer is flagged as the last one of a record, those closing words carry an end-of-record code instead. After the closing words the block keeps the line quiet for a tail time, switches the motor off and pulses a one-cycle completion strobe. After an end-of-record buffer the block stays idle for good until the next reset.

The buffer is read through a combinational read port. The block drives an address, and the buffer returns the byte at that address in the same cycle. The caller gives the number of data bytes and the final-record flag together with the start command. All timing values are parameters counted in clock cycles:
- warm-up time: `WARM_CYC`
- pulse period: `PULSE_PER`
- inter-nibble gap: `NIB_GAP`
- tail time: `END_GAP`

Top module: `nib_tape_enc`

## Requirements
- R1: While reset is applied and directly after it, `motor_o`, `pulse_o` and `done_o` are low.
- R2: A `start_i` seen while the block is idle raises `motor_o` on the next cycle. The first pulse of the buffer rises exactly `WARM_CYC` cycles after `motor_o` rises, and `motor_o` never rises without a `start_i` in the cycle before.
- R3: A nibble of value v is sent as exactly v+1 pulses. Each pulse is high for `PULSE_PER/2` cycles and repeats every `PULSE_PER` cycles.
- R4: Data bytes are read at addresses 0 up to `len_i`-1, in rising order. Each byte is sent high nibble (bits 7:4) first, then low nibble (bits 3:0).
- R5: Between the last pulse of one burst and the first pulse of the next, `pulse_o` stays low for exactly `NIB_GAP + PULSE_PER - PULSE_PER/2` cycles.
- R6: The first buffer after reset is preceded by two start words of value `START_CODE` (default 8'hA5).
- R7: Every buffer ends with three words. They hold `STOP_CODE` (default 8'hF0), or `EOR_CODE` (default 8'hFF) when `last_i` was high with the start command.
- R8: After the last pulse falls, `pulse_o` stays low for `END_GAP + PULSE_PER - PULSE_PER/2` cycles while `motor_o` is high. `motor_o` then falls, and `done_o` is high for exactly one cycle: the first cycle in which `motor_o` is low.
- R9: A `start_i` received while a buffer is being written has no effect on the pulse stream.
- R10: After an end-of-record buffer has completed, `motor_o`, `pulse_o` and `done_o` stay low whatever `start_i` does.
- R11: With `len_i` = 0, only the framing words are sent.
- R12: Buffers after the first one carry no start words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start writing one buffer (sampled when idle) |
| last_i | input | 1 | Buffer closes the record (sampled with `start_i`) |
| len_i | input | AW+1 | Number of data bytes in the buffer |
| rd_addr_o | output | AW | Buffer read address |
| rd_data_i | input | 8 | Byte at `rd_addr_o` (same cycle) |
| motor_o | output | 1 | Recorder motor enable |
| pulse_o | output | 1 | Pulse line to the recorder |
| done_o | output | 1 | One-cycle strobe when a buffer is complete |

## Verification
The bench plays a tape reader. It splits the pulse line into bursts by low-time length and turns each burst count back into a nibble.

Four patterns are tried, and each one separates a different kind of fault:
- The first buffer holds mixed bytes. It shows whether the start framing and the nibble order are right, and whether the count is off by one.
- A second buffer holds 00 and FF bytes and gets a stray start during transmission. It tests the extreme counts 1 and 16, the absence of start words and immunity to the stray start.
- An empty buffer isolates the framing.
- A final buffer followed by further starts shows the end-of-record code and that the block then stays quiet for good.

// File: rtl/nte_pkg.sv
package nte_pkg;

  typedef enum logic [2:0] {
    CS_IDLE,
    CS_WARM,
    CS_BURST,
    CS_GAP,
    CS_TAIL,
    CS_HALT
  } ctl_state_e;

  typedef enum logic [1:0] {
    WS_START,
    WS_DATA,
    WS_STOP
  } word_src_e;

endpackage

// File: rtl/nte_timer.sv
module nte_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [TW-1:0] val_i,
  output logic          zero_o
);

  logic [TW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)             cnt_d = val_i;
    else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/nte_burst.sv
module nte_burst #(
  parameter int PULSE_PER = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go_i,
  input  logic [3:0] nib_i,
  output logic       pulse_o,
  output logic       fin_o
);

  localparam int PW = (PULSE_PER > 2) ? $clog2(PULSE_PER) : 1;
  localparam logic [PW-1:0] PH_LAST = PW'(PULSE_PER - 1);
  localparam logic [PW-1:0] PH_HI   = PW'(PULSE_PER / 2);

  logic          act_q, act_d;
  logic [PW-1:0] ph_q, ph_d;
  logic [4:0]    rem_q, rem_d;

  always_comb begin
    act_d = act_q;
    ph_d  = ph_q;
    rem_d = rem_q;
    if (go_i) begin
      act_d = 1'b1;
      ph_d  = '0;
      rem_d = {1'b0, nib_i} + 5'd1;
    end else if (act_q) begin
      if (ph_q == PH_LAST) begin
        ph_d  = '0;
        rem_d = rem_q - 5'd1;
        if (rem_q == 5'd1) act_d = 1'b0;
      end else begin
        ph_d = ph_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      ph_q  <= '0;
      rem_q <= '0;
    end else begin
      act_q <= act_d;
      ph_q  <= ph_d;
      rem_q <= rem_d;
    end
  end

  assign pulse_o = act_q && (ph_q < PH_HI);
  assign fin_o   = act_q && (ph_q == PH_LAST) && (rem_q == 5'd1);

endmodule

// File: rtl/nte_seq.sv
module nte_seq
  import nte_pkg::*;
#(
  parameter int         AW         = 8,
  parameter logic [7:0] START_CODE = 8'hA5,
  parameter logic [7:0] STOP_CODE  = 8'hF0,
  parameter logic [7:0] EOR_CODE   = 8'hFF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          init_i,
  input  logic          first_i,
  input  logic          last_i,
  input  logic [AW:0]   len_i,
  input  logic          adv_i,
  input  logic [7:0]    rd_data_i,
  output logic [AW-1:0] rd_addr_o,
  output logic [3:0]    nib_o,
  output logic          last_nib_o
);

  word_src_e     src_q, src_d;
  logic [AW-1:0] idx_q, idx_d;
  logic          lo_q, lo_d;
  logic [AW:0]   len_q, len_d;
  logic          eor_q, eor_d;
  logic [7:0]    word;
  logic          word_end;

  always_comb begin
    case (src_q)
      WS_START: word = START_CODE;
      WS_DATA:  word = rd_data_i;
      default:  word = eor_q ? EOR_CODE : STOP_CODE;
    endcase
  end

  always_comb begin
    case (src_q)
      WS_START: word_end = (idx_q == AW'(1));
      WS_DATA:  word_end = ({1'b0, idx_q} == len_q - 1'b1);
      default:  word_end = (idx_q == AW'(2));
    endcase
  end

  always_comb begin
    src_d = src_q;
    idx_d = idx_q;
    lo_d  = lo_q;
    len_d = len_q;
    eor_d = eor_q;
    if (init_i) begin
      len_d = len_i;
      eor_d = last_i;
      idx_d = '0;
      lo_d  = 1'b0;
      if (first_i)           src_d = WS_START;
      else if (len_i == '0)  src_d = WS_STOP;
      else                   src_d = WS_DATA;
    end else if (adv_i) begin
      if (!lo_q) begin
        lo_d = 1'b1;
      end else begin
        lo_d = 1'b0;
        if (word_end && src_q == WS_START) begin
          idx_d = '0;
          src_d = (len_q == '0) ? WS_STOP : WS_DATA;
        end else if (word_end && src_q == WS_DATA) begin
          idx_d = '0;
          src_d = WS_STOP;
        end else if (!word_end) begin
          idx_d = idx_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= WS_STOP;
      idx_q <= '0;
      lo_q  <= 1'b0;
      len_q <= '0;
      eor_q <= 1'b0;
    end else begin
      src_q <= src_d;
      idx_q <= idx_d;
      lo_q  <= lo_d;
      len_q <= len_d;
      eor_q <= eor_d;
    end
  end

  assign rd_addr_o  = idx_q;
  assign nib_o      = lo_q ? word[3:0] : word[7:4];
  assign last_nib_o = (src_q == WS_STOP) && word_end && lo_q;

endmodule

// File: rtl/nte_ctrl.sv
module nte_ctrl
  import nte_pkg::*;
#(
  parameter int TW       = 8,
  parameter int WARM_CYC = 60,
  parameter int NIB_GAP  = 12,
  parameter int END_GAP  = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          last_i,
  input  logic          burst_fin_i,
  input  logic          last_nib_i,
  input  logic          tmr_zero_i,
  output logic          tmr_load_o,
  output logic [TW-1:0] tmr_val_o,
  output logic          burst_go_o,
  output logic          seq_init_o,
  output logic          seq_first_o,
  output logic          seq_adv_o,
  output logic          motor_o,
  output logic          done_o
);

  ctl_state_e st_q, st_d;
  logic first_q, first_d;
  logic eor_q, eor_d;
  logic motor_q, motor_d;
  logic done_q, done_d;

  always_comb begin
    st_d       = st_q;
    first_d    = first_q;
    eor_d      = eor_q;
    motor_d    = motor_q;
    done_d     = 1'b0;
    tmr_load_o = 1'b0;
    tmr_val_o  = '0;
    burst_go_o = 1'b0;
    seq_init_o = 1'b0;
    seq_adv_o  = 1'b0;
    case (st_q)
      CS_IDLE: if (start_i) begin
        st_d       = CS_WARM;
        motor_d    = 1'b1;
        tmr_load_o = 1'b1;
        tmr_val_o  = TW'(WARM_CYC - 1);
        seq_init_o = 1'b1;
        first_d    = 1'b0;
        eor_d      = last_i;
      end
      CS_WARM, CS_GAP: if (tmr_zero_i) begin
        st_d       = CS_BURST;
        burst_go_o = 1'b1;
      end
      CS_BURST: if (burst_fin_i) begin
        seq_adv_o  = 1'b1;
        tmr_load_o = 1'b1;
        if (last_nib_i) begin
          st_d      = CS_TAIL;
          tmr_val_o = TW'(END_GAP - 1);
        end else begin
          st_d      = CS_GAP;
          tmr_val_o = TW'(NIB_GAP - 1);
        end
      end
      CS_TAIL: if (tmr_zero_i) begin
        motor_d = 1'b0;
        done_d  = 1'b1;
        st_d    = eor_q ? CS_HALT : CS_IDLE;
      end
      default: st_d = CS_HALT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= CS_IDLE;
      first_q <= 1'b1;
      eor_q   <= 1'b0;
      motor_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      st_q    <= st_d;
      first_q <= first_d;
      eor_q   <= eor_d;
      motor_q <= motor_d;
      done_q  <= done_d;
    end
  end

  assign seq_first_o = first_q;
  assign motor_o     = motor_q;
  assign done_o      = done_q;

endmodule

// File: rtl/nib_tape_enc.sv
module nib_tape_enc #(
  parameter int         AW         = 8,
  parameter int         WARM_CYC   = 60,
  parameter int         PULSE_PER  = 4,
  parameter int         NIB_GAP    = 12,
  parameter int         END_GAP    = 24,
  parameter logic [7:0] START_CODE = 8'hA5,
  parameter logic [7:0] STOP_CODE  = 8'hF0,
  parameter logic [7:0] EOR_CODE   = 8'hFF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          last_i,
  input  logic [AW:0]   len_i,
  output logic [AW-1:0] rd_addr_o,
  input  logic [7:0]    rd_data_i,
  output logic          motor_o,
  output logic          pulse_o,
  output logic          done_o
);

  localparam int MAX_A = (WARM_CYC > NIB_GAP) ? WARM_CYC : NIB_GAP;
  localparam int MAX_C = (MAX_A > END_GAP) ? MAX_A : END_GAP;
  localparam int TW    = $clog2(MAX_C + 1);

  logic          tmr_load, tmr_zero;
  logic [TW-1:0] tmr_val;
  logic          go, fin, seq_init, seq_first, seq_adv, last_nib;
  logic [3:0]    nib;

  nte_ctrl #(
    .TW(TW), .WARM_CYC(WARM_CYC), .NIB_GAP(NIB_GAP), .END_GAP(END_GAP)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .last_i(last_i),
    .burst_fin_i(fin), .last_nib_i(last_nib), .tmr_zero_i(tmr_zero),
    .tmr_load_o(tmr_load), .tmr_val_o(tmr_val), .burst_go_o(go),
    .seq_init_o(seq_init), .seq_first_o(seq_first), .seq_adv_o(seq_adv),
    .motor_o(motor_o), .done_o(done_o)
  );

  nte_timer #(.TW(TW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load_i(tmr_load), .val_i(tmr_val), .zero_o(tmr_zero)
  );

  nte_seq #(
    .AW(AW), .START_CODE(START_CODE), .STOP_CODE(STOP_CODE), .EOR_CODE(EOR_CODE)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .init_i(seq_init), .first_i(seq_first),
    .last_i(last_i), .len_i(len_i), .adv_i(seq_adv), .rd_data_i(rd_data_i),
    .rd_addr_o(rd_addr_o), .nib_o(nib), .last_nib_o(last_nib)
  );

  nte_burst #(.PULSE_PER(PULSE_PER)) u_burst (
    .clk(clk), .rst_n(rst_n), .go_i(go), .nib_i(nib), .pulse_o(pulse_o), .fin_o(fin)
  );

endmodule

// File: rtl/nte_checker.sv
module nte_checker #(
  parameter int AW        = 8,
  parameter int PULSE_PER = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_i,
  input logic          last_i,
  input logic [AW-1:0] rd_addr_o,
  input logic          motor_o,
  input logic          pulse_o,
  input logic          done_o
);

  localparam int HI = PULSE_PER / 2;

  logic [7:0] hi_run;
  logic       eor_lat;
  logic       halted;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_run  <= '0;
      eor_lat <= 1'b0;
      halted  <= 1'b0;
    end else begin
      hi_run <= pulse_o ? hi_run + 8'd1 : 8'd0;
      if (start_i && !motor_o && !halted) eor_lat <= last_i;
      if (done_o && eor_lat) halted <= 1'b1;
    end
  end

  p_pulse_needs_motor_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_o |-> motor_o);

  p_motor_on_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(motor_o) |-> $past(start_i));

  p_pulse_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_o |-> (hi_run < 8'(HI)));

  p_addr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr_o != $past(rd_addr_o)) |->
      ((rd_addr_o == AW'($past(rd_addr_o) + 1'b1)) || (rd_addr_o == '0)));

  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_done_motor_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!motor_o && $past(motor_o)));

  p_absorb_r10: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> (!motor_o && !pulse_o && !done_o));

endmodule

bind nib_tape_enc nte_checker #(.AW(AW), .PULSE_PER(PULSE_PER)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .last_i(last_i),
  .rd_addr_o(rd_addr_o), .motor_o(motor_o), .pulse_o(pulse_o), .done_o(done_o)
);

// File: tb/nib_tape_enc_tb.sv
module nib_tape_enc_tb;

  localparam int AW = 8;
  localparam int WARM = 60, PER = 4, NGAP = 12, EGAP = 24;
  localparam int HI = PER / 2;
  localparam int EXP_GAP  = NGAP + PER - HI;
  localparam int EXP_TAIL = EGAP + PER - HI + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0, last_i = 1'b0;
  logic [AW:0] len_i = '0;
  logic [AW-1:0] rd_addr_o;
  logic [7:0] rd_data_i;
  logic motor_o, pulse_o, done_o;
  logic [7:0] mem [256];

  int checks = 0, failures = 0;
  int got [0:127];
  int expv [0:127];
  int ngot, nexp, warm_d, hi_bad, gap_bad, tail_low, done_cnt;
  bit done_at_fall, timed_out;

  always #10 clk = ~clk;
  assign rd_data_i = mem[rd_addr_o];

  nib_tape_enc #(.AW(AW), .WARM_CYC(WARM), .PULSE_PER(PER),
                 .NIB_GAP(NGAP), .END_GAP(EGAP)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .last_i(last_i), .len_i(len_i),
    .rd_addr_o(rd_addr_o), .rd_data_i(rd_data_i),
    .motor_o(motor_o), .pulse_o(pulse_o), .done_o(done_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp_v);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
    end
  endtask

  task automatic push_exp(input int b);
    expv[nexp] = (b >> 4) & 15; nexp++;
    expv[nexp] = b & 15;        nexp++;
  endtask

  // Writes one buffer, decoding the pulse line like a tape reader
  task automatic run_buffer(input int len, input bit last, input bit first, input int poke);
    int cyc, pcount, low_run, hi_run, mrise, frise, fell_cyc;
    bit prev_p, prev_m, fell;
    nexp = 0;
    if (first) begin push_exp(8'hA5); push_exp(8'hA5); end
    for (int i = 0; i < len; i++) push_exp(mem[i]);
    for (int i = 0; i < 3; i++) push_exp(last ? 8'hFF : 8'hF0);
    ngot = 0; hi_bad = 0; gap_bad = 0; done_cnt = 0; tail_low = -1;
    done_at_fall = 0; timed_out = 0;
    cyc = 0; pcount = 0; low_run = 0; hi_run = 0; mrise = -1; frise = -1;
    prev_p = 0; prev_m = 0; fell = 0; fell_cyc = 0;
    @(negedge clk);
    len_i = (AW+1)'(len); last_i = last; start_i = 1'b1;
    while (!(fell && cyc > fell_cyc + 3)) begin
      @(negedge clk);
      cyc++;
      start_i = (poke > 0 && cyc == poke);
      if (motor_o && !prev_m) mrise = cyc;
      if (pulse_o && !prev_p) begin
        if (frise < 0) frise = cyc;
        if (pcount > 0 && low_run > PER) begin
          if (low_run != EXP_GAP) gap_bad++;
          if (ngot < 128) got[ngot] = pcount - 1;
          ngot++; pcount = 0;
        end
        pcount++; hi_run = 0;
      end
      if (!pulse_o && prev_p) begin
        if (hi_run != HI) hi_bad++;
        low_run = 0;
      end
      if (pulse_o) hi_run++; else low_run++;
      if (done_o) done_cnt++;
      if (!motor_o && prev_m && !fell) begin
        if (pcount > 0) begin if (ngot < 128) got[ngot] = pcount - 1; ngot++; end
        tail_low = low_run; done_at_fall = done_o; fell = 1; fell_cyc = cyc;
      end
      prev_p = pulse_o; prev_m = motor_o;
      if (cyc > 30000) begin timed_out = 1; break; end
    end
    start_i = 1'b0;
    warm_d = frise - mrise;
    chk(!timed_out, "R8 buffer completes", timed_out, 0);
    chk(mrise == 1, "R2 motor rises after start", mrise, 1);
    chk(warm_d == WARM, "R2 warm-up to first pulse", warm_d, WARM);
    chk(hi_bad == 0, "R3 pulse high width", hi_bad, 0);
    chk(gap_bad == 0, "R5 inter-nibble low time", gap_bad, 0);
    chk(ngot == nexp, "R3 R4 nibble count", ngot, nexp);
    for (int i = 0; i < nexp && i < ngot; i++)
      chk(got[i] == expv[i], $sformatf("R3 R4 nibble %0d value", i), got[i], expv[i]);
    chk(tail_low == EXP_TAIL, "R8 tail low time", tail_low, EXP_TAIL);
    chk(done_at_fall, "R8 done with motor fall", done_at_fall, 1);
    chk(done_cnt == 1, "R8 done width", done_cnt, 1);
  endtask

  task automatic t_reset();
    chk(!motor_o && !pulse_o && !done_o, "R1 outputs low in reset",
        {motor_o, pulse_o, done_o}, 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!motor_o && !pulse_o && !done_o, "R1 outputs low after reset",
        {motor_o, pulse_o, done_o}, 0);
  endtask

  task automatic t_first_buffer();
    mem[0] = 8'h3C; mem[1] = 8'h91; mem[2] = 8'h5E;
    run_buffer(3, 1'b0, 1'b1, 0);
    chk(ngot > 3 && got[0] == 10 && got[1] == 5 && got[2] == 10 && got[3] == 5,
        "R6 start words first", got[0], 10);
    chk(ngot >= 6 && got[ngot-6] == 15 && got[ngot-5] == 0 && got[ngot-1] == 0,
        "R7 stop words", got[ngot-1], 0);
  endtask

  task automatic t_second_buffer();
    mem[0] = 8'h00; mem[1] = 8'hFF; mem[2] = 8'h0F; mem[3] = 8'hF0;
    run_buffer(4, 1'b0, 1'b0, 150);   // stray start mid-stream: R9
    chk(ngot > 0 && got[0] == 0, "R12 no start words on later buffer", got[0], 0);
    chk(ngot == 14, "R9 stray start leaves stream intact", ngot, 14);
  endtask

  task automatic t_empty();
    run_buffer(0, 1'b0, 1'b0, 0);
    chk(ngot == 6, "R11 empty buffer sends framing only", ngot, 6);
  endtask

  task automatic t_final_and_absorb();
    int seen;
    mem[0] = 8'h27; mem[1] = 8'h48;
    run_buffer(2, 1'b1, 1'b0, 0);
    chk(ngot >= 6 && got[ngot-6] == 15 && got[ngot-5] == 15 && got[ngot-1] == 15,
        "R7 end-of-record code", got[ngot-5], 15);
    seen = 0;
    for (int k = 0; k < 300; k++) begin
      @(negedge clk);
      start_i = (k % 50 == 0);
      if (motor_o || pulse_o || done_o) seen++;
    end
    start_i = 1'b0;
    chk(seen == 0, "R10 absorbing after final buffer", seen, 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    t_reset();
    t_first_buffer();
    t_second_buffer();
    t_empty();
    t_final_and_absorb();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++; checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule